// File: doc/BRIEF.md
# NAND Flash Controller Front End

This block sits between a register bus and an 8- or 16-bit NAND flash device. Software queues command, address, data-write and read-request entries into a small write buffer. A bus sequencer turns each entry into one NAND bus cycle and drives the latch-enable, chip-enable and strobe pins. The read and write strobe low times are set by delay fields in the control register. The state of the ready/busy pin and of the buffer is reported through a status register and through a sticky, write-one-to-clear event register.

Besides single cycles, the block can move one whole ECC section of 256 or 512 bytes on its own. A page read sends every word it samples out on a data stream port. A page write pulls every word it drives from a valid/ready source. A transfer counter counts the words of the current section, and software can clear it through a reset register. Its busy bit shows when that clear is in progress.

Top module: `nand_front`

## Requirements
- R1: After reset, the NAND strobes and the chip enable are high, and the latch enables are low. The status register (address 1) reads 0x11, which means the device is not busy and the buffer is empty. The event register (address 2) reads 0.
- R2: Each write to address 3 (command), 4 (address) or 5 (data) produces one WE_n low pulse, in the order the writes were made. A command cycle has CLE high and ALE low, an address cycle has ALE high and CLE low, and a data cycle has both low. The written value is on nd_dout during the pulse.
- R3: The write buffer holds 4 entries. A queued write that arrives while the buffer is full is discarded and sets event bit1. Status bit1 shows that the buffer is full.
- R4: Strobe delays are set in the control register (address 0): bits[7:4] for the read delay and bits[11:8] for the write delay. RE_n or WE_n stays low for 1 + delay clock cycles, and the two strobes are never low at the same time.
- R5: Any write to address 6 queues one RE_n cycle. When that cycle ends, event bit3 is set and address 7 returns the sampled data.
- R6: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: With control bit1 at 0 (8-bit bus), the upper byte of nd_dout is 0 and the upper byte of read data is 0. With control bit1 at 1, all 16 bits are used.
- R8: Writing bit0 of the page control register (address 9) starts a page read, and status bit3 stays high until it ends. Each sampled word appears once, in order, on pg_rdata with a one-cycle pg_rvalid pulse.
- R9: Writing bit1 of the page control register starts a page write. It takes one word per pg_wvalid/pg_wready handshake and drives each word in a data cycle. Status bit2 stays high until the last word has been driven, and then event bit4 is set.
- R10: A section is 256 bytes when control bit0 is 0 and 512 bytes when it is 1. The word count is the section size divided by the bus width in bytes. When a page ends, the transfer counter (address 10) equals that word count.
- R11: Writing 1 to bit0 of the reset register (address 8) clears the transfer counter. Bit0 of address 8 reads 1 on the read that immediately follows the write, and reads 0 once the clear has finished.
- R12: Status bit0 follows the ready pin after a two-stage synchronizer. A low-to-high change of the ready pin sets event bit0.
- R13: Event bit2 is set when the write buffer goes from holding entries to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the cycle after reg_rd |
| pg_wvalid | input | 1 | Page write word valid |
| pg_wdata | input | 16 | Page write word |
| pg_wready | output | 1 | Page write word accepted when high with pg_wvalid |
| pg_rvalid | output | 1 | Page read word pulse |
| pg_rdata | output | 16 | Page read word |
| nd_ce_n | output | 1 | Chip enable, low active |
| nd_cle | output | 1 | Command latch enable |
| nd_ale | output | 1 | Address latch enable |
| nd_we_n | output | 1 | Write strobe, low active |
| nd_re_n | output | 1 | Read strobe, low active |
| nd_dout | output | 16 | Data driven to the device |
| nd_doe | output | 1 | Output enable for nd_dout |
| nd_din | input | 16 | Data from the device |
| nd_rdy | input | 1 | Device ready (high) / busy (low) |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have passed. They also assume that nd_rdy may change at any time, because it goes through the synchronizer. They assume that software never starts a page transfer while queued entries are still waiting. The stimulus keeps to these limits: every page transfer and every reset-register write is issued only after the buffer and the sequencer have gone idle. The single overflow burst is made against a slow strobe setting, so that the buffer is known to be full when the extra write arrives.

// File: rtl/nf_pkg.sv
package nf_pkg;
  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WR, OP_RD} nf_op_e;
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} nf_state_e;
  typedef logic [3:0] nf_addr_t;

  localparam nf_addr_t RA_CTRL   = 4'd0;
  localparam nf_addr_t RA_STAT   = 4'd1;
  localparam nf_addr_t RA_EVT    = 4'd2;
  localparam nf_addr_t RA_CMD    = 4'd3;
  localparam nf_addr_t RA_ADDR   = 4'd4;
  localparam nf_addr_t RA_WDATA  = 4'd5;
  localparam nf_addr_t RA_RDREQ  = 4'd6;
  localparam nf_addr_t RA_RDATA  = 4'd7;
  localparam nf_addr_t RA_CLR    = 4'd8;
  localparam nf_addr_t RA_PAGE   = 4'd9;
  localparam nf_addr_t RA_COUNT  = 4'd10;
endpackage

// File: rtl/nf_wbuf.sv
module nf_wbuf #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
endmodule

// File: rtl/nf_seq.sv
module nf_seq
  import nf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  nf_op_e          op,
  input  logic [DW-1:0]   wdata,
  input  logic            wide,
  input  logic [DLYW-1:0] rd_dly,
  input  logic [DLYW-1:0] wr_dly,
  input  logic [DW-1:0]   din,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic [DW-1:0]   dout,
  output logic            doe
);
  localparam int HW = DW / 2;

  nf_state_e       st;
  nf_op_e          op_q;
  logic            wide_q;
  logic [DLYW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      op_q   <= OP_CMD;
      wide_q <= 1'b0;
      cnt    <= '0;
      dout   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          wide_q <= wide;
          dout   <= wide ? wdata : {{HW{1'b0}}, wdata[HW-1:0]};
          cnt    <= (op == OP_RD) ? rd_dly : wr_dly;
          st     <= S_SETUP;
        end
        S_SETUP: st <= S_STRB;
        S_STRB: begin
          if (cnt == '0) begin
            st <= S_HOLD;
            if (op_q == OP_RD)
              rdata <= wide_q ? din : {{HW{1'b0}}, din[HW-1:0]};
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign cle  = busy && (op_q == OP_CMD);
  assign ale  = busy && (op_q == OP_ADDR);
  assign doe  = busy && (op_q != OP_RD);
  assign we_n = !((st == S_STRB) && (op_q != OP_RD));
  assign re_n = !((st == S_STRB) && (op_q == OP_RD));
endmodule

// File: rtl/nand_front.sv
module nand_front
  import nf_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DEPTH      = 4,
  parameter int SECT_BYTES = 256,
  parameter int DLYW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pg_wvalid,
  input  logic [DW-1:0] pg_wdata,
  output logic          pg_wready,
  output logic          pg_rvalid,
  output logic [DW-1:0] pg_rdata,
  output logic          nd_ce_n,
  output logic          nd_cle,
  output logic          nd_ale,
  output logic          nd_we_n,
  output logic          nd_re_n,
  output logic [DW-1:0] nd_dout,
  output logic          nd_doe,
  input  logic [DW-1:0] nd_din,
  input  logic          nd_rdy
);
  localparam int EW = DW + 2;
  localparam int CW = $clog2(2 * SECT_BYTES) + 1;

  logic            psel, wide;
  logic [DLYW-1:0] rdly, wdly;
  logic            rdy_s1, rdy_s2, rdy_s3, empty_d;
  logic [4:0]      irq_q, irq_set;
  logic            page_rd, page_wr, cur_page, cur_rd;
  logic [CW-1:0]   issued, xfer_cnt, nwords;
  logic [1:0]      rst_cnt;
  logic [DW-1:0]   rd_hold;

  // write buffer
  logic          q_wr, push, wb_full, wb_empty, fifo_go, page_go, start;
  nf_op_e        q_op, s_op;
  logic [EW-1:0] f_vec;
  logic [DW-1:0] s_data, seq_rdata;
  logic          seq_busy, seq_done, last_word;

  always_comb begin
    q_wr = reg_wr;
    case (reg_addr)
      RA_CMD:   q_op = OP_CMD;
      RA_ADDR:  q_op = OP_ADDR;
      RA_WDATA: q_op = OP_WR;
      RA_RDREQ: q_op = OP_RD;
      default: begin
        q_op = OP_CMD;
        q_wr = 1'b0;
      end
    endcase
  end

  assign push = q_wr && !wb_full;

  nf_wbuf #(.W(EW), .DEPTH(DEPTH)) u_wbuf (
    .clk(clk), .rst(rst), .push(push), .din({q_op, reg_wdata}),
    .pop(fifo_go), .dout(f_vec), .full(wb_full), .empty(wb_empty)
  );

  // section length in bus words
  always_comb begin
    case ({psel, wide})
      2'b00:   nwords = CW'(SECT_BYTES);
      2'b01:   nwords = CW'(SECT_BYTES / 2);
      2'b10:   nwords = CW'(2 * SECT_BYTES);
      default: nwords = CW'(SECT_BYTES);
    endcase
  end

  assign pg_wready = !seq_busy && wb_empty && page_wr && (issued < nwords);
  assign fifo_go   = !seq_busy && !wb_empty;
  assign page_go   = !seq_busy && wb_empty && (issued < nwords) &&
                     (page_rd || (page_wr && pg_wvalid));
  assign start     = fifo_go || page_go;
  assign s_op      = fifo_go ? nf_op_e'(f_vec[EW-1:DW]) : (page_rd ? OP_RD : OP_WR);
  assign s_data    = fifo_go ? f_vec[DW-1:0] : pg_wdata;
  assign last_word = (xfer_cnt + CW'(1)) == nwords;

  nf_seq #(.DW(DW), .DLYW(DLYW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(s_op), .wdata(s_data),
    .wide(wide), .rd_dly(rdly), .wr_dly(wdly), .din(nd_din),
    .busy(seq_busy), .done(seq_done), .rdata(seq_rdata),
    .cle(nd_cle), .ale(nd_ale), .we_n(nd_we_n), .re_n(nd_re_n),
    .dout(nd_dout), .doe(nd_doe)
  );

  assign irq_set = {page_wr && seq_done && cur_page && last_word,
                    seq_done && !cur_page && cur_rd,
                    wb_empty && !empty_d,
                    q_wr && wb_full,
                    rdy_s2 && !rdy_s3};

  always_ff @(posedge clk) begin
    if (rst) begin
      {psel, wide} <= 2'b00;
      rdly      <= '0;
      wdly      <= '0;
      {rdy_s1, rdy_s2, rdy_s3} <= 3'b111;
      empty_d   <= 1'b1;
      irq_q     <= '0;
      page_rd   <= 1'b0;
      page_wr   <= 1'b0;
      cur_page  <= 1'b0;
      cur_rd    <= 1'b0;
      issued    <= '0;
      xfer_cnt  <= '0;
      rst_cnt   <= '0;
      rd_hold   <= '0;
      pg_rvalid <= 1'b0;
      pg_rdata  <= '0;
      reg_rdata <= '0;
    end else begin
      {rdy_s1, rdy_s2, rdy_s3} <= {nd_rdy, rdy_s1, rdy_s2};
      empty_d   <= wb_empty;
      pg_rvalid <= 1'b0;
      if (reg_wr && reg_addr == RA_CTRL) begin
        psel <= reg_wdata[0];
        wide <= reg_wdata[1];
        rdly <= reg_wdata[4 +: DLYW];
        wdly <= reg_wdata[8 +: DLYW];
      end
      if (start) begin
        cur_page <= page_go && !fifo_go;
        cur_rd   <= (s_op == OP_RD);
        if (!fifo_go) issued <= issued + CW'(1);
      end
      if (seq_done) begin
        if (cur_page) begin
          xfer_cnt <= xfer_cnt + CW'(1);
          if (page_rd) begin
            pg_rvalid <= 1'b1;
            pg_rdata  <= seq_rdata;
          end
          if (last_word) begin
            page_rd <= 1'b0;
            page_wr <= 1'b0;
          end
        end else if (cur_rd) begin
          rd_hold <= seq_rdata;
        end
      end
      if (reg_wr && reg_addr == RA_PAGE && !page_rd && !page_wr &&
          (reg_wdata[0] || reg_wdata[1])) begin
        page_rd  <= reg_wdata[0];
        page_wr  <= !reg_wdata[0];
        issued   <= '0;
        xfer_cnt <= '0;
      end
      if (reg_wr && reg_addr == RA_CLR && reg_wdata[0]) rst_cnt <= 2'd2;
      else if (rst_cnt != 2'd0) rst_cnt <= rst_cnt - 1'b1;
      if (rst_cnt != 2'd0) begin
        xfer_cnt <= '0;
        issued   <= '0;
      end
      if (reg_wr && reg_addr == RA_EVT) irq_q <= (irq_q & ~reg_wdata[4:0]) | irq_set;
      else irq_q <= irq_q | irq_set;
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL:  reg_rdata <= DW'({wdly, rdly, 2'b00, wide, psel});
          RA_STAT:  reg_rdata <= DW'({wb_empty, page_rd, page_wr, wb_full, rdy_s2});
          RA_EVT:   reg_rdata <= DW'(irq_q);
          RA_RDATA: reg_rdata <= rd_hold;
          RA_CLR:   reg_rdata <= DW'(rst_cnt != 2'd0);
          RA_PAGE:  reg_rdata <= DW'({page_wr, page_rd});
          RA_COUNT: reg_rdata <= DW'(xfer_cnt);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  assign nd_ce_n = !(seq_busy || page_rd || page_wr);
endmodule

// File: rtl/nf_chk.sv
module nf_chk (
  input logic       clk,
  input logic       rst,
  input logic       nd_cle,
  input logic       nd_ale,
  input logic       nd_we_n,
  input logic       nd_re_n,
  input logic       reg_wr,
  input logic [3:0] reg_addr,
  input logic       wdata0,
  input logic       q_full,
  input logic       irq_ovf,
  input logic       page_rd,
  input logic       page_wr,
  input logic [1:0] rst_cnt
);
  logic [5:0] we_low;

  always_ff @(posedge clk) begin
    if (rst) we_low <= '0;
    else if (!nd_we_n) we_low <= we_low + 1'b1;
    else we_low <= '0;
  end

  a_r2_latch_excl: assert property (@(posedge clk) disable iff (rst)
    !(nd_cle && nd_ale));

  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!nd_we_n && !nd_re_n));

  a_r4_we_width: assert property (@(posedge clk) disable iff (rst)
    we_low <= 6'd16);

  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && q_full && reg_addr >= 4'd3 && reg_addr <= 4'd6) |=> irq_ovf);

  a_r8_one_page: assert property (@(posedge clk) disable iff (rst)
    $onehot0({page_rd, page_wr}));

  a_r11_clr_busy: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd8 && wdata0) |=> (rst_cnt != 2'd0));
endmodule

bind nand_front nf_chk u_nf_chk (
  .clk(clk), .rst(rst), .nd_cle(nd_cle), .nd_ale(nd_ale),
  .nd_we_n(nd_we_n), .nd_re_n(nd_re_n), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .wdata0(reg_wdata[0]), .q_full(wb_full),
  .irq_ovf(irq_q[1]), .page_rd(page_rd), .page_wr(page_wr),
  .rst_cnt(rst_cnt)
);

// File: tb/test_nand_front.sv
module test_nand_front;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MDL_BASE = 16'h3C11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        pg_wvalid = 1'b0;
  logic [15:0] pg_wdata = '0;
  logic        pg_wready, pg_rvalid;
  logic [15:0] pg_rdata;
  logic        nd_ce_n, nd_cle, nd_ale, nd_we_n, nd_re_n, nd_doe;
  logic [15:0] nd_dout, nd_din;
  logic        nd_rdy = 1'b1;

  int n_chk = 0, n_fail = 0;
  int mdl_cnt = 0;
  logic [17:0] wlog [0:1023];
  int wlog_n = 0;
  logic [15:0] rs [0:1023];
  int rs_n = 0;
  int we_run = 0, re_run = 0, last_we_w = 0, last_re_w = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_front i_nand_front (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pg_wvalid(pg_wvalid), .pg_wdata(pg_wdata), .pg_wready(pg_wready),
    .pg_rvalid(pg_rvalid), .pg_rdata(pg_rdata), .nd_ce_n(nd_ce_n),
    .nd_cle(nd_cle), .nd_ale(nd_ale), .nd_we_n(nd_we_n), .nd_re_n(nd_re_n),
    .nd_dout(nd_dout), .nd_doe(nd_doe), .nd_din(nd_din), .nd_rdy(nd_rdy)
  );

  // device model: a new word after every read strobe
  assign nd_din = MDL_BASE + 16'(mdl_cnt) * 16'h0101;
  always @(posedge nd_re_n) if (!rst) mdl_cnt = mdl_cnt + 1;

  always @(posedge nd_we_n) if (!rst) begin
    wlog[wlog_n] = {nd_cle, nd_ale, nd_dout};
    wlog_n = wlog_n + 1;
  end

  always @(negedge clk) if (!rst) begin
    if (pg_rvalid) begin
      rs[rs_n] = pg_rdata;
      rs_n = rs_n + 1;
    end
    if (!nd_we_n) we_run = we_run + 1;
    else if (we_run != 0) begin last_we_w = we_run; we_run = 0; end
    if (!nd_re_n) re_run = re_run + 1;
    else if (re_run != 0) begin last_re_w = re_run; re_run = 0; end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // callers sit at a negedge; tasks return at a negedge
  task automatic wr(logic [3:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 pins", {nd_ce_n, nd_we_n, nd_re_n, nd_cle, nd_ale}, 5'b11100);
    rd(4'd1, v); chk("R1 status", v, 16'h0011);
    rd(4'd2, v); chk("R1 events", v, 16'h0000);
  endtask

  task automatic t_cmd_addr;
    int b;
    b = wlog_n;
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'hAB5A);
    wr(4'd4, 16'h0033);
    wr(4'd5, 16'h12C4);
    idle(30);
    chk("R2 cycle count", wlog_n - b, 3);
    chk("R2 R7 command cycle", wlog[b],   {2'b10, 16'h005A});
    chk("R2 address cycle",    wlog[b+1], {2'b01, 16'h0033});
    chk("R2 R7 data cycle",    wlog[b+2], {2'b00, 16'h00C4});
  endtask

  task automatic t_strobe_width;
    wr(4'd0, 16'h0950);
    wr(4'd3, 16'h0070);
    idle(30);
    chk("R4 write strobe width", last_we_w, 10);
  endtask

  task automatic t_single_read;
    logic [15:0] v, exp;
    wr(4'd2, 16'h001F);
    exp = (MDL_BASE + 16'(mdl_cnt) * 16'h0101) & 16'h00FF;
    wr(4'd6, 16'hFFFF);
    idle(30);
    chk("R4 read strobe width", last_re_w, 6);
    rd(4'd2, v); chk("R5 read ready event", v[3], 1'b1);
    rd(4'd7, v); chk("R5 R7 read data", v, exp);
  endtask

  task automatic t_ready_w1c;
    logic [15:0] v;
    nd_rdy = 1'b0; idle(5);
    rd(4'd1, v); chk("R12 status busy", v[0], 1'b0);
    nd_rdy = 1'b1; idle(5);
    rd(4'd1, v); chk("R12 status ready", v[0], 1'b1);
    rd(4'd2, v); chk("R12 ready event", v[3:0] & 4'b1001, 4'b1001);
    wr(4'd2, 16'h0001);
    rd(4'd2, v); chk("R6 write-one-to-clear", v[3:0] & 4'b1001, 4'b1000);
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    int b;
    wr(4'd0, 16'h0F00);
    wr(4'd2, 16'h001F);
    b = wlog_n;
    for (int i = 0; i < 6; i++) wr(4'd3, 16'(8'h40 + i));
    rd(4'd1, v); chk("R3 full status", v[1], 1'b1);
    idle(150);
    chk("R3 discarded write", wlog_n - b, 5);
    chk("R3 last kept entry", wlog[b+4], {2'b10, 16'h0044});
    rd(4'd2, v); chk("R3 R13 overflow and empty events", v[2:1], 2'b11);
    rd(4'd1, v); chk("R3 drained status", v[4:1], 4'b1000);
  endtask

  task automatic t_page_read(logic psel, int n, string tag);
    logic [15:0] v;
    int b, c0, bad, g;
    wr(4'd0, {14'd0, 1'b1, psel});
    b = rs_n; c0 = mdl_cnt; bad = 0; g = 0;
    wr(4'd9, 16'h0001);
    rd(4'd1, v); chk({tag, " R8 read pending"}, v[3], 1'b1);
    while (rs_n - b < n && g < 20000) begin @(negedge clk); g++; end
    idle(10);
    chk({tag, " R8 word count"}, rs_n - b, n);
    for (int i = 0; i < n; i++)
      if (rs[b+i] !== MDL_BASE + 16'(c0 + i) * 16'h0101) bad++;
    chk({tag, " R8 stream data"}, bad, 0);
    rd(4'd1, v); chk({tag, " R8 pending cleared"}, v[3], 1'b0);
    rd(4'd10, v); chk({tag, " R10 transfer count"}, v, 16'(n));
  endtask

  task automatic t_clear;
    logic [15:0] v;
    wr(4'd8, 16'h0001);
    rd(4'd8, v); chk("R11 clear busy", v[0], 1'b1);
    idle(5);
    rd(4'd8, v); chk("R11 clear done", v[0], 1'b0);
    rd(4'd10, v); chk("R11 counter cleared", v, 16'h0000);
  endtask

  task automatic t_page_write;
    logic [15:0] v, src;
    int b, hs, g, bad;
    logic will;
    wr(4'd0, 16'h0000);
    wr(4'd2, 16'h001F);
    b = wlog_n; src = 16'hA501; hs = 0; g = 0; bad = 0;
    pg_wdata = src;
    wr(4'd9, 16'h0002);
    rd(4'd1, v); chk("R9 write pending", v[2], 1'b1);
    pg_wvalid = 1'b1;
    while (hs < 256 && g < 20000) begin
      will = pg_wready;
      @(posedge clk); @(negedge clk);
      if (will) begin hs++; src = src + 16'h0103; pg_wdata = src; end
      g++;
    end
    pg_wvalid = 1'b0;
    idle(30);
    chk("R9 data cycles", wlog_n - b, 256);
    for (int i = 0; i < 256; i++)
      if (wlog[b+i] !== {2'b00, 8'h00, 8'(16'hA501 + 16'(i) * 16'h0103)}) bad++;
    chk("R9 R7 driven words", bad, 0);
    rd(4'd1, v); chk("R9 pending cleared", v[2], 1'b0);
    rd(4'd2, v); chk("R9 done event", v[4], 1'b1);
    rd(4'd10, v); chk("R10 write transfer count", v, 16'd256);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cmd_addr();
    t_strobe_width();
    t_single_read();
    t_ready_w1c();
    t_overflow();
    wr(4'd0, 16'h0000);
    t_page_read(1'b1, 256, "large16");
    t_clear();
    t_page_read(1'b0, 128, "small16");
    t_page_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule